// File: doc/BRIEF.md
# Time-Space Slot Interchange Switch

This block switches four serial time-division streams onto four serial output streams. Each frame holds 32 slots of 8 bits. Any slot of any input can be placed into any slot of any output, so one block moves data in both time and space. A phase accumulator derives the bit rate from the system clock. With the default parameters, a 50 MHz clock gives 2.048 Mbit/s per stream. The block drives a bit strobe and a frame-sync pulse, and all inputs and outputs are aligned to them.

Each input is shifted into bytes. At the end of every slot, each byte is written into an output-ordered frame buffer. The write address comes from a connection memory, which is indexed by the source (input, slot) and holds the destination (output, slot). Two buffers alternate each frame. Bytes written during one frame are shifted out during the next frame.

Connections are programmed one at a time with a 14-bit word and a save strobe. A single command reloads the whole memory with a pseudo-random permutation.

Top module: `tdm_slot_switch`

## Requirements
- R1: `bit_strobe` fires with an average rate of ACC_INC/ACC_MOD per clock (a phase accumulator adds ACC_INC modulo ACC_MOD each cycle). When 2*ACC_INC <= ACC_MOD, it never fires on two consecutive cycles.
- R2: A frame is 256 strobes long. `frame_sync` is high together with the strobe of bit 0 of slot 0. Input bits are sampled at the clock edge that ends a strobe cycle. Slot s, bit b (bytes are MSB first) is the strobe with index 8*s+b in the frame.
- R3: The output bit of strobe index p is driven from the edge that ends strobe cycle p until the next strobe edge. Bytes received in input frame n leave in output frame n+1. With the reset map, every output equals the matching input one frame later.
- R4: After reset, `ser_out` is 0, `busy` is 0, and the connection map is the identity. The first output frame after reset is all zero.
- R5: `cfg_word` carries the source input in bits [13:12], the source slot in [11:7], the destination output in [6:5] and the destination slot in [4:0]. A `cfg_save` pulse while not busy writes the destination into the map entry of that source.
- R6: A saved connection takes effect at the next frame boundary. Bytes of the frame in which the save happens still use the old map.
- R7: A destination slot that no source targets sends 0x00.
- R8: When several sources target one destination: among sources in the same slot, the higher input number wins; otherwise, the source in the later slot wins.
- R9: A `rand_go` pulse while not busy resets the map to identity and then runs a 127-swap random shuffle, one swap per clock. `busy` stays high for exactly 127 cycles, and the result is a permutation of all 128 destinations.
- R10: While `busy` is high, `cfg_save` and `rand_go` are ignored. The map in use is not updated until the shuffle completes.
- R11: When `rand_go` and `cfg_save` arrive in the same cycle, the shuffle is started and the save is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 4 | Serial input streams, one bit each |
| cfg_word | input | 14 | Connection word: source and destination |
| cfg_save | input | 1 | Write strobe for `cfg_word` |
| rand_go | input | 1 | Start a random permutation load |
| ser_out | output | 4 | Serial output streams |
| bit_strobe | output | 1 | One-cycle pulse per bit period |
| frame_sync | output | 1 | Marks bit 0 of slot 0 |
| busy | output | 1 | Shuffle in progress |

## Verification
The bench uses the same slot number on two inputs that target one destination; a wrong priority shows the lower input's byte there. It also makes a later-slot source collide with an earlier-slot source in the other direction. A save made early in a frame is checked against two frames that must still show the old map; a design that applied writes immediately would alter the second of those frames. After each random load, the bench checks the output frame as a multiset. It also applies save and start pulses during the shuffle and in the same cycle as the start. A design that honoured any of these would duplicate or lose a byte, or would stretch `busy` past 127 cycles.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int NPORT      = 4;
  localparam int NSLOT      = 32;
  localparam int SBITS      = 8;
  localparam int PORT_W     = $clog2(NPORT);
  localparam int SLOT_W     = $clog2(NSLOT);
  localparam int BIT_W      = $clog2(SBITS);
  localparam int ENT_W      = PORT_W + SLOT_W;
  localparam int NENT       = NPORT * NSLOT;
  localparam int FRAME_BITS = NSLOT * SBITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int CFG_W      = 2 * ENT_W;
  localparam int LFSR_W     = 16;

  typedef logic [NENT-1:0][ENT_W-1:0] map_t;

  function automatic map_t identity_map();
    map_t m;
    for (int k = 0; k < NENT; k++) m[k] = ENT_W'(k);
    return m;
  endfunction
endpackage

// File: rtl/tss_rst_sync.sv
module tss_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tss_bit_timer.sv
module tss_bit_timer import tss_pkg::*; #(
  parameter int ACC_INC = 2048000,
  parameter int ACC_MOD = 50000000
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             bit_en,
  output logic [POS_W-1:0] pos,
  output logic             frame_sync,
  output logic             frame_end
);
  localparam int ACC_W = $clog2(ACC_MOD + ACC_INC) + 1;

  logic [ACC_W-1:0] acc_q, acc_d, acc_sum;
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    acc_sum = acc_q + ACC_W'(ACC_INC);
    bit_en  = (acc_sum >= ACC_W'(ACC_MOD));
    acc_d   = bit_en ? (acc_sum - ACC_W'(ACC_MOD)) : acc_sum;
    pos_d   = bit_en ? (pos_q + 1'b1) : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      pos_q <= '0;
    end else begin
      acc_q <= acc_d;
      pos_q <= pos_d;
    end
  end

  assign pos        = pos_q;
  assign frame_sync = bit_en && (pos_q == '0);
  assign frame_end  = bit_en && (pos_q == POS_W'(FRAME_BITS - 1));

  // strobes counted between frame marks, for the checks below
  logic [POS_W:0] strobe_cnt_q;
  logic           seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_cnt_q <= '0;
      seen_q       <= 1'b0;
    end else if (bit_en) begin
      strobe_cnt_q <= frame_sync ? (POS_W+1)'(1) : strobe_cnt_q + 1'b1;
      if (frame_sync) seen_q <= 1'b1;
    end
  end

  generate
    if (2 * ACC_INC <= ACC_MOD) begin : g_gap
      // R1
      strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> !bit_en);
    end
  endgenerate

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && seen_q) |-> (strobe_cnt_q == (POS_W+1)'(FRAME_BITS)));
endmodule

// File: rtl/tss_conn_map.sv
module tss_conn_map import tss_pkg::*; #(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CFG_W-1:0]            cfg_word,
  input  logic                        cfg_save,
  input  logic                        rand_go,
  input  logic                        frame_end,
  input  logic [SLOT_W-1:0]           rd_slot,
  output logic [NPORT-1:0][ENT_W-1:0] dest,
  output logic                        busy
);
  localparam int PROD_W = 2 * ENT_W + 1;
  localparam int SWAPS  = NENT - 1;

  map_t              cfg_q, cfg_d, act_q, act_d;
  logic              busy_q, busy_d;
  logic [ENT_W-1:0]  idx_q, idx_d, swap_j;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [PROD_W-1:0] prod;

  // random pick in [0, idx]: scale a 7-bit random value by idx+1
  always_comb begin
    prod   = PROD_W'(lfsr_q[ENT_W-1:0]) * (PROD_W'(idx_q) + PROD_W'(1));
    swap_j = prod[2*ENT_W-1:ENT_W];
    lfsr_d = {lfsr_q[LFSR_W-2:0],
              lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_comb begin
    cfg_d  = cfg_q;
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      cfg_d[idx_q]  = cfg_q[swap_j];
      cfg_d[swap_j] = cfg_q[idx_q];
      idx_d         = idx_q - 1'b1;
      if (idx_q == ENT_W'(1)) busy_d = 1'b0;
    end else if (rand_go) begin
      cfg_d  = identity_map();
      idx_d  = ENT_W'(NENT - 1);
      busy_d = 1'b1;
    end else if (cfg_save) begin
      cfg_d[cfg_word[CFG_W-1:ENT_W]] = cfg_word[ENT_W-1:0];
    end
    act_d = (frame_end && !busy_q) ? cfg_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= identity_map();
      act_q  <= identity_map();
      busy_q <= 1'b0;
      idx_q  <= '0;
      lfsr_q <= LFSR_SEED;
    end else begin
      cfg_q  <= cfg_d;
      act_q  <= act_d;
      busy_q <= busy_d;
      idx_q  <= idx_d;
      lfsr_q <= lfsr_d;
    end
  end

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_lookup
      assign dest[g] = act_q[{PORT_W'(g), rd_slot}];
    end
  endgenerate

  assign busy = busy_q;

  // length of the current busy run, for the checks below
  logic [ENT_W:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len_q <= '0;
    else if (busy_q) run_len_q <= run_len_q + 1'b1;
    else             run_len_q <= '0;
  end

  // R9
  shuffle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (run_len_q == (ENT_W+1)'(SWAPS)));

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_q));

  // R10
  act_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(act_q));
endmodule

// File: rtl/tss_frame_store.sv
module tss_frame_store import tss_pkg::*; (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_en,
  input  logic [POS_W-1:0]            pos,
  input  logic                        frame_end,
  input  logic [NPORT-1:0]            ser_in,
  input  logic [NPORT-1:0][ENT_W-1:0] dest,
  output logic [NPORT-1:0]            ser_out
);
  localparam int NBANK = 2;

  logic [SBITS-2:0]            shift_q [NPORT];
  logic [SBITS-1:0]            mem_q   [NBANK][NENT];
  logic [NBANK-1:0][NENT-1:0]  vld_q, vld_d;
  logic                        bank_q, bank_d, rd_bank;
  logic                        slot_end;
  logic [BIT_W-1:0]            bit_idx;
  logic [SLOT_W-1:0]           slot_idx;
  logic [NPORT-1:0]            rd_bit;

  assign bit_idx  = pos[BIT_W-1:0];
  assign slot_idx = pos[POS_W-1:BIT_W];
  assign slot_end = bit_en && (bit_idx == BIT_W'(SBITS - 1));
  assign rd_bank  = ~bank_q;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_rd
      logic [ENT_W-1:0] raddr;
      logic [SBITS-1:0] rbyte;
      assign raddr     = {PORT_W'(g), slot_idx};
      assign rbyte     = mem_q[rd_bank][raddr];
      assign rd_bit[g] = vld_q[rd_bank][raddr] & rbyte[BIT_W'(SBITS - 1) - bit_idx];
    end
  endgenerate

  always_comb begin
    vld_d  = vld_q;
    bank_d = bank_q;
    if (slot_end) begin
      for (int p = 0; p < NPORT; p++) vld_d[bank_q][dest[p]] = 1'b1;
    end
    if (frame_end) begin
      vld_d[rd_bank] = '0;
      bank_d         = rd_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      bank_q <= bank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) shift_q[p] <= '0;
      ser_out <= '0;
    end else if (bit_en) begin
      for (int p = 0; p < NPORT; p++) shift_q[p] <= {shift_q[p][SBITS-3:0], ser_in[p]};
      ser_out <= rd_bit;
    end
  end

  // higher input index is written last and so wins a same-slot collision
  always_ff @(posedge clk) begin
    if (slot_end) begin
      for (int p = 0; p < NPORT; p++) mem_q[bank_q][dest[p]] <= {shift_q[p], ser_in[p]};
    end
  end
endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch import tss_pkg::*; #(
  parameter int                ACC_INC   = 2048000,
  parameter int                ACC_MOD   = 50000000,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] ser_in,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cfg_save,
  input  logic             rand_go,
  output logic [NPORT-1:0] ser_out,
  output logic             bit_strobe,
  output logic             frame_sync,
  output logic             busy
);
  logic                        rst_n_s;
  logic                        bit_en, frame_end;
  logic [POS_W-1:0]            pos;
  logic [NPORT-1:0][ENT_W-1:0] dest;

  tss_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  tss_bit_timer #(.ACC_INC(ACC_INC), .ACC_MOD(ACC_MOD)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bit_en     (bit_en),
    .pos        (pos),
    .frame_sync (frame_sync),
    .frame_end  (frame_end)
  );

  tss_conn_map #(.LFSR_SEED(LFSR_SEED)) u_map (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_word  (cfg_word),
    .cfg_save  (cfg_save),
    .rand_go   (rand_go),
    .frame_end (frame_end),
    .rd_slot   (pos[POS_W-1:BIT_W]),
    .dest      (dest),
    .busy      (busy)
  );

  tss_frame_store u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bit_en    (bit_en),
    .pos       (pos),
    .frame_end (frame_end),
    .ser_in    (ser_in),
    .dest      (dest),
    .ser_out   (ser_out)
  );

  assign bit_strobe = bit_en;

  // R4
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (ser_out == '0 && !busy));
endmodule

// File: tb/tdm_slot_switch_bench.sv
module tdm_slot_switch_bench;
  localparam int INC = 3;
  localparam int MOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ser_in;
  logic [13:0] cfg_word = '0;
  logic       cfg_save = 1'b0;
  logic       rand_go = 1'b0;
  logic [3:0] ser_out;
  logic       bit_strobe, frame_sync, busy;

  always #10 clk = ~clk;

  tdm_slot_switch #(.ACC_INC(INC), .ACC_MOD(MOD)) u_tdm_slot_switch (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .cfg_word(cfg_word),
    .cfg_save(cfg_save), .rand_go(rand_go), .ser_out(ser_out),
    .bit_strobe(bit_strobe), .frame_sync(frame_sync), .busy(busy));

  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] src_byte(int p, int s);
    return {1'b1, 2'(p), 5'(s)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stream driver and collector
  int         pos = 0;
  bit         synced = 0;
  int         bits_seen = 0;
  int         out_cnt = 0;
  int         prev;
  logic [7:0] acc [4][32];
  logic [7:0] got [4][32];
  logic [7:0] last_perm [4][32];

  always @(negedge clk) begin
    if (bit_strobe) begin
      if (frame_sync) pos = 0; else pos = (pos + 1) % 256;
      if (synced) begin
        prev = (pos + 255) % 256;
        for (int p = 0; p < 4; p++) acc[p][prev / 8][7 - (prev % 8)] = ser_out[p];
        bits_seen++;
        if (prev == 255) begin
          if (bits_seen >= 256) begin
            got = acc;
            out_cnt++;
          end
          bits_seen = 0;
        end
      end
      if (frame_sync) synced = 1;
      for (int p = 0; p < 4; p++)
        ser_in[p] = synced ? src_byte(p, pos / 8)[7 - (pos % 8)] : 1'b0;
    end
  end

  task automatic wait_frames(int n);
    int target;
    target = out_cnt + n;
    while (out_cnt < target) @(negedge clk);
  endtask

  // reference model of the map in use
  logic [6:0] mdl [128];
  logic [7:0] exp_out [4][32];

  task automatic build_exp();
    int d;
    for (int p = 0; p < 4; p++) for (int s = 0; s < 32; s++) exp_out[p][s] = 8'h00;
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        d = mdl[p * 32 + s];
        exp_out[d / 32][d % 32] = src_byte(p, s);
      end
  endtask

  task automatic check_model(string req);
    int bad;
    build_exp();
    bad = 0;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 32; s++)
        if (got[p][s] !== exp_out[p][s]) bad++;
    chk(bad == 0, req, "frame mismatches", bad, 0);
  endtask

  task automatic do_save(int ip, int is, int op, int os);
    @(negedge clk);
    cfg_word = {2'(ip), 5'(is), 2'(op), 5'(os)};
    cfg_save = 1'b1;
    @(negedge clk);
    cfg_save = 1'b0;
  endtask

  task automatic check_perm(string req);
    int cnt [256];
    int once, same;
    for (int v = 0; v < 256; v++) cnt[v] = 0;
    for (int p = 0; p < 4; p++) for (int s = 0; s < 32; s++) cnt[got[p][s]]++;
    once = 0;
    for (int v = 128; v < 256; v++) if (cnt[v] == 1) once++;
    chk(once == 128, req, "distinct source bytes", once, 128);
    same = 0;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 32; s++)
        if (got[p][s] == src_byte(p, s)) same++;
    chk(same < 128, req, "identity positions", same, 127);
  endtask

  // R4: reset state and first frame
  task automatic t_reset();
    int nz;
    repeat (3) @(negedge clk);
    chk(ser_out == 4'h0, "R4", "ser_out after reset", ser_out, 0);
    chk(busy == 1'b0, "R4", "busy after reset", busy, 0);
    wait_frames(1);
    nz = 0;
    for (int p = 0; p < 4; p++) for (int s = 0; s < 32; s++) if (got[p][s] != 0) nz++;
    chk(nz == 0, "R4", "nonzero bytes in first frame", nz, 0);
    wait_frames(1);
    check_model("R3");
  endtask

  // R1, R2: strobe rate and frame length
  task automatic t_timing();
    int n, adj, len;
    bit last;
    n = 0; adj = 0; last = 0;
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      if (bit_strobe) n++;
      if (bit_strobe && last) adj++;
      last = bit_strobe;
    end
    chk(n == 300, "R1", "strobes in 1000 cycles", n, 300);
    chk(adj == 0, "R1", "back-to-back strobes", adj, 0);
    do @(negedge clk); while (!frame_sync);
    len = 0;
    do begin
      @(negedge clk);
      if (bit_strobe) len++;
    end while (!frame_sync);
    chk(len == 256, "R2", "strobes per frame", len, 256);
  endtask

  // R5, R6, R7, R8: same-slot collision and frame-boundary timing
  task automatic t_save_same_slot();
    wait_frames(1);
    do_save(2, 7, 0, 7);
    wait_frames(2);
    check_model("R6");
    mdl[2 * 32 + 7] = 7'd7;
    wait_frames(1);
    check_model("R5");
    chk(got[0][7] == src_byte(2, 7), "R8", "same-slot winner", got[0][7], src_byte(2, 7));
    chk(got[2][7] == 8'h00, "R7", "orphan slot", got[2][7], 0);
  endtask

  // R8: earlier-slot source loses to later slot
  task automatic t_save_later_slot();
    do_save(3, 2, 1, 4);
    mdl[3 * 32 + 2] = 7'(1 * 32 + 4);
    wait_frames(3);
    check_model("R8");
    chk(got[1][4] == src_byte(1, 4), "R8", "later slot wins", got[1][4], src_byte(1, 4));
    chk(got[3][2] == 8'h00, "R7", "orphan slot", got[3][2], 0);
  endtask

  task automatic run_busy(output int n);
    n = 0;
    while (busy) begin
      n++;
      if (n == 20) begin
        cfg_word = {2'd0, 5'd0, 2'd3, 5'd31};
        cfg_save = 1'b1;
        rand_go  = 1'b1;
      end else begin
        cfg_save = 1'b0;
        rand_go  = 1'b0;
      end
      @(negedge clk);
    end
    cfg_save = 1'b0;
    rand_go  = 1'b0;
  endtask

  // R9, R10: shuffle with pulses applied mid-run
  task automatic t_shuffle();
    int n;
    @(negedge clk);
    rand_go = 1'b1;
    @(negedge clk);
    rand_go = 1'b0;
    run_busy(n);
    chk(n == 127, "R10", "busy cycles with mid-run pulses", n, 127);
    wait_frames(3);
    check_perm("R9");
    last_perm = got;
  endtask

  // R11: start and save in the same cycle
  task automatic t_both();
    int n, diff;
    @(negedge clk);
    cfg_word = {2'd0, 5'd0, 2'd3, 5'd31};
    cfg_save = 1'b1;
    rand_go  = 1'b1;
    @(negedge clk);
    cfg_save = 1'b0;
    rand_go  = 1'b0;
    run_busy(n);
    chk(n == 127, "R11", "busy cycles", n, 127);
    wait_frames(3);
    check_perm("R11");
    diff = 0;
    for (int p = 0; p < 4; p++) for (int s = 0; s < 32; s++) if (got[p][s] != last_perm[p][s]) diff++;
    chk(diff > 0, "R9", "differs from previous shuffle", diff, 1);
  endtask

  initial begin
    for (int k = 0; k < 128; k++) mdl[k] = 7'(k);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_save_same_slot();
    t_save_later_slot();
    t_shuffle();
    t_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule